// File: doc/BRIEF.md
# Crosstalk Coincidence Filter for One Front-End Chip Group

This block cleans up the hits of one readout chip that serves eight neighbouring wire channels. For each event window it is given, per channel, a hit flag, an 11-bit drift-time count and an amplitude value. Crosstalk between channels on one chip shows up as many channels firing at almost the same time. When the chip has at least four hits, the block searches the time-sorted hits for the largest group whose earliest and latest times lie within a fixed window. It marks that group as crosstalk and removes it from the output.

Independently of timing, a channel can be dropped by a dead-channel mask or by a minimum-amplitude cut. Each of these has its own enable. A caller presents the inputs together with a one-cycle `start`. The block sorts the eight hits with a small compare-exchange network and then tests one group size and one start position per cycle. It then raises `done` for one cycle with the surviving hits in `keep`.

Top module: `xtalk_filter`

## Requirements
- R1: While reset is active and after it is released, `keep` is 0 and `done` is 0 until the first event completes.
- R2: `start` is accepted only while no event is in progress. All inputs are captured in the accepted cycle, and a `start` raised during a search is ignored. `done` is a single-cycle pulse, and `keep` changes only in the `done` cycle and holds its value until the next `done`.
- R3: With the default 8 channels, `done` is visible no later than 16 clock cycles after the cycle in which `start` was accepted.
- R4: If fewer than 4 channels have `hit_valid` set, no hit is treated as crosstalk.
- R5: A group of hits is coincident when its largest time count minus its smallest is at most 16. A spread of exactly 16 qualifies and a spread of 17 does not.
- R6: Group sizes are tried from the number of valid hits down to 4. The first size with a qualifying group wins, and the marked channels are the original channels of that group in time order.
- R7: Within one group size, groups are tried from the earliest-time start position upward, and only the first qualifying group is marked.
- R8: A channel with `hit_valid` low never appears in `keep` and takes no part in counting or grouping, whatever its time count.
- R9: With `mask_en` high, a channel whose `dead_mask` bit is set is never kept. With `mask_en` low, `dead_mask` has no effect.
- R10: With `cut_en` high, a hit whose `adc_in` value is below `adc_thr` is dropped, and a value equal to the threshold is kept. With `cut_en` low, amplitudes have no effect.
- R11: Hits removed by the mask or by the amplitude cut still count toward the crosstalk coincidence search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin an event |
| hit_valid | input | CH | Per-channel hit flag |
| tdc_in | input | CH*TW | Per-channel time count, channel i at bits [i*TW +: TW] |
| adc_in | input | CH*AW | Per-channel amplitude, channel i at bits [i*AW +: AW] |
| dead_mask | input | CH | Per-channel dead flag |
| mask_en | input | 1 | Enable the dead-channel mask |
| cut_en | input | 1 | Enable the amplitude cut |
| adc_thr | input | AW | Amplitude threshold |
| keep | output | CH | Surviving hits, valid with `done` |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its defaults: eight channels, 11-bit times, 8-bit amplitudes, a window of 16 and a minimum of four hits. With these values, the full eight-hit search with no qualifying group is reachable, and it sets the worst-case latency checked against the 16-cycle bound. Channel times are assigned out of order, so the marked set shows whether the sort carries channel identities correctly. The window edge is probed at spreads of 16 and 17. Separate vectors show the preference for the larger group and for the earlier start when two equal-size groups both qualify.

// File: rtl/xtalk_filter.sv
module xtalk_filter #(
  parameter int CH       = 8,
  parameter int TW       = 11,
  parameter int AW       = 8,
  parameter int WIN      = 16,
  parameter int MIN_HITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CH-1:0]      hit_valid,
  input  logic [CH*TW-1:0]   tdc_in,
  input  logic [CH*AW-1:0]   adc_in,
  input  logic [CH-1:0]      dead_mask,
  input  logic               mask_en,
  input  logic               cut_en,
  input  logic [AW-1:0]      adc_thr,
  output logic [CH-1:0]      keep,
  output logic               done
);
  localparam int CW = $clog2(CH + 1);
  localparam int IW = (CH > 1) ? $clog2(CH) : 1;

  logic [TW:0]   sk [CH];
  logic [IW-1:0] si [CH];
  logic [TW:0]   tk;
  logic [IW-1:0] ti;

  always_comb begin
    tk = '0;
    ti = '0;
    for (int i = 0; i < CH; i++) begin
      sk[i] = {~hit_valid[i], tdc_in[i*TW +: TW]};
      si[i] = IW'(i);
    end
    for (int s = 0; s < CH; s++) begin
      for (int j = s % 2; j < CH - 1; j += 2) begin
        if (sk[j] > sk[j+1]) begin
          tk = sk[j];  sk[j] = sk[j+1];  sk[j+1] = tk;
          ti = si[j];  si[j] = si[j+1];  si[j+1] = ti;
        end
      end
    end
  end

  logic [CH-1:0] low;
  for (genvar g = 0; g < CH; g++) begin : g_low
    assign low[g] = adc_in[g*AW +: AW] < adc_thr;
  end

  wire [CH-1:0] base_in = hit_valid & ~(mask_en ? dead_mask : '0) & ~(cut_en ? low : '0);
  wire [CW-1:0] n_in    = CW'($countones(hit_valid));

  logic [TW-1:0] st_tdc [CH];
  logic [IW-1:0] st_id  [CH];
  logic [CH-1:0] base;
  logic [CW-1:0] nh, sz, pos;
  logic          busy;

  wire [CW-1:0] last   = pos + sz - CW'(1);
  wire [TW-1:0] spread = st_tdc[last[IW-1:0]] - st_tdc[pos[IW-1:0]];
  wire          fits   = spread <= TW'(WIN);

  logic [CH-1:0] gmask;
  always_comb begin
    gmask = '0;
    for (int i = 0; i < CH; i++)
      if (CW'(i) >= pos && CW'(i) < pos + sz) gmask[st_id[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep <= '0;
      done <= 1'b0;
      busy <= 1'b0;
      base <= '0;
      nh   <= '0;
      sz   <= '0;
      pos  <= '0;
      for (int i = 0; i < CH; i++) begin
        st_tdc[i] <= '0;
        st_id[i]  <= '0;
      end
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          base <= base_in;
          nh   <= n_in;
          for (int i = 0; i < CH; i++) begin
            st_tdc[i] <= sk[i][TW-1:0];
            st_id[i]  <= si[i];
          end
          if (n_in < CW'(MIN_HITS)) begin
            keep <= base_in;
            done <= 1'b1;
          end else begin
            busy <= 1'b1;
            sz   <= n_in;
            pos  <= '0;
          end
        end
      end else if (fits) begin
        keep <= base & ~gmask;
        done <= 1'b1;
        busy <= 1'b0;
      end else if (pos + sz < nh) begin
        pos <= pos + CW'(1);
      end else if (sz > CW'(MIN_HITS)) begin
        sz  <= sz - CW'(1);
        pos <= '0;
      end else begin
        keep <= base;
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xtalk_filter_chk.sv
module xtalk_filter_chk #(
  parameter int CH       = 8,
  parameter int MIN_HITS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CH-1:0] hit_valid,
  input logic [CH-1:0] dead_mask,
  input logic          mask_en,
  input logic          cut_en,
  input logic [CH-1:0] keep,
  input logic          done
);
  localparam int LIMIT = (CH - MIN_HITS + 1) * (CH - MIN_HITS + 2) / 2 + 1;

  logic          busy_c;
  logic [7:0]    cnt;
  logic [CH-1:0] lv, ld;
  logic          lme, lce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      cnt    <= '0;
      lv     <= '0;
      ld     <= '0;
      lme    <= 1'b0;
      lce    <= 1'b0;
    end else begin
      if (busy_c && cnt != 8'hFF) cnt <= cnt + 8'd1;
      if (done) busy_c <= 1'b0;
      if (start && (!busy_c || done)) begin
        busy_c <= 1'b1;
        cnt    <= '0;
        lv     <= hit_valid;
        ld     <= dead_mask;
        lme    <= mask_en;
        lce    <= cut_en;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $past(start))); // R2
  AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(keep) |-> done); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_c && !done) |-> (cnt < 8'(LIMIT))); // R3
  AST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((keep & ~lv) == '0)); // R8
  AST_DEAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lme) |-> ((keep & ld) == '0)); // R9
  AST_FEW_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($countones(lv) < MIN_HITS) && !lme && !lce) |-> (keep == lv)); // R4
endmodule

bind xtalk_filter xtalk_filter_chk #(.CH(CH), .MIN_HITS(MIN_HITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .hit_valid(hit_valid),
  .dead_mask(dead_mask), .mask_en(mask_en), .cut_en(cut_en),
  .keep(keep), .done(done)
);

// File: tb/xtalk_filter_tb.sv
module xtalk_filter_tb;
  typedef struct packed {
    logic [7:0]       v;
    logic [7:0][10:0] t;
    logic [7:0][7:0]  a;
    logic [7:0]       d;
    logic             me;
    logic             ce;
    logic [7:0]       thr;
    logic [7:0]       exp;
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R6: all eight within 14 counts
    '{8'hFF, {11'd102,11'd106,11'd110,11'd114,11'd112,11'd108,11'd104,11'd100}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h00, 4'd6},
    // R4: three hits only
    '{8'h07, {11'd0,11'd0,11'd0,11'd0,11'd0,11'd12,11'd11,11'd10}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h07, 4'd4},
    // R5: spread of exactly 16
    '{8'h0F, {11'd0,11'd0,11'd0,11'd0,11'd16,11'd10,11'd5,11'd0}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h00, 4'd5},
    // R5: spread of 17
    '{8'h0F, {11'd0,11'd0,11'd0,11'd0,11'd17,11'd10,11'd5,11'd0}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h0F, 4'd5},
    // R6: four of six in a middle group
    '{8'h3F, {11'd0,11'd0,11'd400,11'd214,11'd210,11'd205,11'd200,11'd0}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h21, 4'd6},
    // R6: scrambled channel order
    '{8'h3F, {11'd0,11'd0,11'd20,11'd10,11'd26,11'd0,11'd14,11'd30}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h05, 4'd6},
    // R7: two qualifying groups of four, earlier wins
    '{8'hFF, {11'd12,11'd112,11'd8,11'd108,11'd4,11'd104,11'd0,11'd100}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h55, 4'd7},
    // R9: mask enabled
    '{8'h07, {11'd0,11'd0,11'd0,11'd0,11'd0,11'd300,11'd200,11'd100}, {8{8'd100}}, 8'h02, 1'b1, 1'b0, 8'd0, 8'h05, 4'd9},
    // R9: mask disabled
    '{8'h07, {11'd0,11'd0,11'd0,11'd0,11'd0,11'd300,11'd200,11'd100}, {8{8'd100}}, 8'h02, 1'b0, 1'b0, 8'd0, 8'h07, 4'd9},
    // R10: cut enabled, 49 dropped, 50 kept
    '{8'h07, {11'd0,11'd0,11'd0,11'd0,11'd0,11'd300,11'd200,11'd100}, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd200,8'd50,8'd49}, 8'h00, 1'b0, 1'b1, 8'd50, 8'h06, 4'd10},
    // R10: cut disabled
    '{8'h07, {11'd0,11'd0,11'd0,11'd0,11'd0,11'd300,11'd200,11'd100}, {8'd0,8'd0,8'd0,8'd0,8'd0,8'd200,8'd50,8'd49}, 8'h00, 1'b0, 1'b0, 8'd50, 8'h07, 4'd10},
    // R8: invalid channels with close times do not count
    '{8'h07, {11'd1,11'd1,11'd1,11'd1,11'd1,11'd2,11'd1,11'd0}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h07, 4'd8},
    // R9: masked channel among four spread hits
    '{8'h0F, {11'd0,11'd0,11'd0,11'd0,11'd150,11'd100,11'd50,11'd0}, {8{8'd100}}, 8'h08, 1'b1, 1'b0, 8'd0, 8'h07, 4'd9},
    // R11: masked hit completes a coincidence
    '{8'h0F, {11'd0,11'd0,11'd0,11'd0,11'd3,11'd2,11'd1,11'd0}, {8{8'd100}}, 8'h08, 1'b1, 1'b0, 8'd0, 8'h00, 4'd11},
    // R11: low-amplitude hit completes a coincidence
    '{8'h0F, {11'd0,11'd0,11'd0,11'd0,11'd3,11'd2,11'd1,11'd0}, {8'd100,8'd100,8'd100,8'd100,8'd100,8'd100,8'd100,8'd10}, 8'h00, 1'b0, 1'b1, 8'd50, 8'h00, 4'd11},
    // R8: invalid channels never join a group
    '{8'h0F, {11'd3,11'd2,11'd1,11'd0,11'd300,11'd200,11'd100,11'd0}, {8{8'd100}}, 8'h00, 1'b0, 1'b0, 8'd0, 8'h0F, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  hit_valid = '0;
  logic [87:0] tdc_in = '0;
  logic [63:0] adc_in = '0;
  logic [7:0]  dead_mask = '0;
  logic        mask_en = 1'b0;
  logic        cut_en = 1'b0;
  logic [7:0]  adc_thr = '0;
  logic [7:0]  keep;
  logic        done;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xtalk_filter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_valid(hit_valid),
    .tdc_in(tdc_in), .adc_in(adc_in), .dead_mask(dead_mask),
    .mask_en(mask_en), .cut_en(cut_en), .adc_thr(adc_thr),
    .keep(keep), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    hit_valid = v.v;
    tdc_in    = v.t;
    adc_in    = v.a;
    dead_mask = v.d;
    mask_en   = v.me;
    cut_en    = v.ce;
    adc_thr   = v.thr;
  endtask

  task automatic kick(output int cyc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(keep == 8'h00 && done == 1'b0, "R1 reset", {keep, 7'b0, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(keep == 8'h00 && done == 1'b0, "R1 after release", {keep, 7'b0, done}, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      kick(cyc);
      chk(done == 1'b1, $sformatf("R%0d vec %0d done", VECS[i].req, i), done, 1);
      chk(keep == VECS[i].exp, $sformatf("R%0d vec %0d keep", VECS[i].req, i), keep, VECS[i].exp);
      chk(cyc <= 16, $sformatf("R3 vec %0d latency", i), cyc, 16);
      held = keep;
      apply('0);
      @(negedge clk);
      chk(done == 1'b0 && keep == held, $sformatf("R2 vec %0d pulse/hold", i), {keep, 7'b0, done}, {held, 8'h00});
    end

    // R3: worst case, eight hits and no qualifying group
    hit_valid = 8'hFF;
    tdc_in = {11'd700,11'd600,11'd500,11'd400,11'd300,11'd200,11'd100,11'd0};
    adc_in = {8{8'd100}};
    dead_mask = '0; mask_en = 1'b0; cut_en = 1'b0; adc_thr = '0;
    kick(cyc);
    chk(cyc == 16, "R3 worst-case latency", cyc, 16);
    chk(keep == 8'hFF, "R3 worst-case keep", keep, 8'hFF);
    @(negedge clk);

    // R2: start during a search is ignored
    apply(VECS[6]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    apply(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    apply('0);
    cyc = 5;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1 && keep == 8'h55, "R2 busy start ignored", keep, 8'h55);
    @(negedge clk);
    cyc = 0;
    for (int k = 0; k < 20; k++) begin
      if (done) cyc++;
      @(negedge clk);
    end
    chk(cyc == 0, "R2 no second result", cyc, 0);
    chk(keep == 8'h55, "R2 keep held", keep, 8'h55);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule